// File: doc/BRIEF.md
# Approximate-Match Dual-CAM Product Cache

This block answers a multiply request from a table of precomputed products instead of computing it, if both operands look like stored patterns. One content-addressable array holds representative weight values and a second one holds representative activation values. Both arrays are searched in the same cycle. When each array reports a matching row, the two row numbers together select a word in a product memory, and that word is returned as the result. When either array finds no match, the request is reported as a miss, and the surrounding datapath has to compute the product itself.

Matching is approximate. Each array stores only the upper `KEY_W` bits of an `OP_W`-bit IEEE-754 operand. A runtime key-length register decides how many of those stored bits, counted from the sign bit downward, take part in the comparison. Lowering the key length lets nearby values share a stored product, which raises the hit rate at some cost in accuracy. A single load port fills weight rows, activation rows and product words, and it also sets the key length. Two counters report how many searches and how many hits have occurred.

Top module: `approx_product_cache`

## Requirements
- R1: When `srch_valid` is high and both arrays match, on the following cycle `rsp_valid` and `rsp_hit` are high and `rsp_result` equals the product word at address weight_row × `A_ROWS` + activation_row.
- R2: When either array has no matching valid row, on the following cycle `rsp_miss` is high, `rsp_hit` is low and `rsp_result` is zero.
- R3: Only the top `abit` bits of the stored `KEY_W`-bit key (operand bits `OP_W-1` downward) are compared. Operand bits below that point have no effect on the outcome.
- R4: If several valid rows of one array match, the row with the lowest index is used.
- R5: Reset clears every row's valid bit, so a search without loads misses. Reset also clears both counters and `rsp_valid`, and it sets the key length to `KEY_W`.
- R6: The key length is loaded with `ld_sel`=3 from `ld_data`. A value above `KEY_W` is stored as `KEY_W`. A key length of 0 makes every valid row match.
- R7: `search_count` increments once per cycle with `srch_valid` high, and `hit_count` increments once per hit. Both values are visible together with the response.
- R8: A cycle without `srch_valid` yields `rsp_valid`, `rsp_hit` and `rsp_miss` all low on the next cycle.
- R9: With `ld_en` high, `ld_sel` selects the target: 0 writes and validates weight row `ld_addr`, 1 writes and validates activation row `ld_addr`, and 2 writes product word `ld_addr`. A row stores `ld_data[OP_W-1 -: KEY_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 weight row, 1 activation row, 2 product word, 3 key length |
| ld_addr | input | ADDR_W | Row index or product address |
| ld_data | input | OP_W | Operand pattern, product word or key length |
| srch_valid | input | 1 | Search request |
| srch_w | input | OP_W | Weight operand |
| srch_a | input | OP_W | Activation operand |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Both arrays matched |
| rsp_miss | output | 1 | At least one array missed |
| rsp_result | output | OP_W | Cached product, zero on miss |
| search_count | output | CNT_W | Searches since reset |
| hit_count | output | CNT_W | Hits since reset |

## Verification
The hardest case to reach is a search in which one operand matches two rows at the same time. This happens only when the key length is shorter than the stored key and two stored patterns differ only in the masked bits. The stimulus loads two weight rows that differ in the lowest stored key bit. It then shortens the key length so that both rows match, and checks that the lower row's product is returned. The same operand, searched with the full key length, must select the upper row. Further directed steps cover a clamped key length, a zero key length, and a reset in the middle of the run that invalidates every loaded row.

// File: rtl/approx_cache_pkg.sv
package approx_cache_pkg;

   typedef enum logic [1:0] {
      LD_WEIGHT = 2'd0,
      LD_ACT    = 2'd1,
      LD_PROD   = 2'd2,
      LD_ABIT   = 2'd3
   } ld_target_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/apc_operand_cam.sv
module apc_operand_cam
   import approx_cache_pkg::*;
#(
   parameter int ROWS  = 16,
   parameter int KEY_W = 16,
   localparam int IDX_W = idx_bits(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_row,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [KEY_W-1:0] key_mask,
   input  logic [KEY_W-1:0] srch_key,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   logic [ROWS-1:0]  row_valid;
   logic [KEY_W-1:0] row_key [ROWS];
   logic [ROWS-1:0]  match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_valid <= '0;
      end else if (wr_en) begin
         row_valid[wr_row] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         row_key[wr_row] <= wr_key;
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign match[r] = row_valid[r] &&
                        (((row_key[r] ^ srch_key) & key_mask) == '0);
   end

   always_comb begin
      idx = '0;
      for (int r = ROWS - 1; r >= 0; r--) begin
         if (match[r]) idx = IDX_W'(r);
      end
   end

   assign hit = |match;

   // R4: selected row matches and no lower row matches
   a_r4_lowest_row: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (match[idx] && ((match & ((ROWS'(1) << idx) - ROWS'(1))) == '0)));

   // R5: an array with no valid row never reports a hit
   a_r5_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid == '0) |-> !hit);

endmodule

// File: rtl/apc_product_sram.sv
module apc_product_sram #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("apc_product_sram: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_addr) < DEPTH)) begin
         mem[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_data <= mem[rd_addr];
      end
   end

endmodule

// File: rtl/approx_product_cache.sv
module approx_product_cache
   import approx_cache_pkg::*;
#(
   parameter int OP_W   = 32,
   parameter int KEY_W  = 16,
   parameter int W_ROWS = 16,
   parameter int A_ROWS = 16,
   parameter int CNT_W  = 32,
   localparam int DEPTH  = W_ROWS * A_ROWS,
   localparam int ADDR_W = idx_bits(DEPTH),
   localparam int WI_W   = idx_bits(W_ROWS),
   localparam int AI_W   = idx_bits(A_ROWS),
   localparam int AB_W   = $clog2(KEY_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [1:0]        ld_sel,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [OP_W-1:0]   ld_data,
   input  logic              srch_valid,
   input  logic [OP_W-1:0]   srch_w,
   input  logic [OP_W-1:0]   srch_a,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [OP_W-1:0]   rsp_result,
   output logic [CNT_W-1:0]  search_count,
   output logic [CNT_W-1:0]  hit_count
);

   if (KEY_W > OP_W || KEY_W < 1) begin : g_bad_key
      $error("approx_product_cache: KEY_W must lie in 1..OP_W");
   end
   if (W_ROWS > 512 || A_ROWS > 512 || W_ROWS < 2 || A_ROWS < 2) begin : g_bad_rows
      $error("approx_product_cache: row counts must lie in 2..512");
   end

   ld_target_e        ld_tgt;
   logic [AB_W-1:0]   abit_q;
   logic [KEY_W-1:0]  key_mask;
   logic              w_hit, a_hit, dual_hit;
   logic [WI_W-1:0]   w_idx;
   logic [AI_W-1:0]   a_idx;
   logic [ADDR_W-1:0] prod_addr;
   logic [OP_W-1:0]   prod_q;

   assign ld_tgt = ld_target_e'(ld_sel);

   // key length register, clamped to the stored key width
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abit_q <= AB_W'(KEY_W);
      end else if (ld_en && ld_tgt == LD_ABIT) begin
         if (ld_data > OP_W'(KEY_W)) abit_q <= AB_W'(KEY_W);
         else                        abit_q <= ld_data[AB_W-1:0];
      end
   end

   always_comb begin
      for (int j = 0; j < KEY_W; j++) begin
         key_mask[j] = (j >= (KEY_W - int'(abit_q)));
      end
   end

   apc_operand_cam #(.ROWS(W_ROWS), .KEY_W(KEY_W)) u_wcam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ld_en && ld_tgt == LD_WEIGHT),
      .wr_row   (ld_addr[WI_W-1:0]),
      .wr_key   (ld_data[OP_W-1 -: KEY_W]),
      .key_mask (key_mask),
      .srch_key (srch_w[OP_W-1 -: KEY_W]),
      .hit      (w_hit),
      .idx      (w_idx)
   );

   apc_operand_cam #(.ROWS(A_ROWS), .KEY_W(KEY_W)) u_acam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ld_en && ld_tgt == LD_ACT),
      .wr_row   (ld_addr[AI_W-1:0]),
      .wr_key   (ld_data[OP_W-1 -: KEY_W]),
      .key_mask (key_mask),
      .srch_key (srch_a[OP_W-1 -: KEY_W]),
      .hit      (a_hit),
      .idx      (a_idx)
   );

   assign dual_hit  = w_hit && a_hit;
   assign prod_addr = ADDR_W'(w_idx) * ADDR_W'(A_ROWS) + ADDR_W'(a_idx);

   apc_product_sram #(.DEPTH(DEPTH), .DATA_W(OP_W), .ADDR_W(ADDR_W)) u_prod (
      .clk     (clk),
      .wr_en   (ld_en && ld_tgt == LD_PROD),
      .wr_addr (ld_addr),
      .wr_data (ld_data),
      .rd_en   (srch_valid && dual_hit),
      .rd_addr (prod_addr),
      .rd_data (prod_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         search_count <= '0;
         hit_count    <= '0;
      end else begin
         rsp_valid <= srch_valid;
         rsp_hit   <= srch_valid && dual_hit;
         rsp_miss  <= srch_valid && !dual_hit;
         if (srch_valid) search_count <= search_count + 1'b1;
         if (srch_valid && dual_hit) hit_count <= hit_count + 1'b1;
      end
   end

   assign rsp_result = rsp_hit ? prod_q : '0;

   a_r2_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_miss));

   a_r1_hit_is_response: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_miss) |-> rsp_valid);

   a_r8_request_gives_response: assert property (@(posedge clk) disable iff (!rst_n)
      srch_valid |=> (rsp_valid && (rsp_hit || rsp_miss)));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

   a_r7_search_step: assert property (@(posedge clk) disable iff (!rst_n)
      srch_valid |=> (search_count == $past(search_count) + 1'b1));

   a_r7_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      hit_count <= search_count);

   a_r6_abit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(abit_q) <= KEY_W);

endmodule

// File: tb/approx_product_cache_test.sv
module approx_product_cache_test;

   localparam int OP_W = 32;
   localparam int KEY_W = 16;
   localparam int WR = 4;
   localparam int AR = 4;
   localparam int CNT_W = 32;
   localparam int ADDR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_en = 1'b0;
   logic [1:0] ld_sel = '0;
   logic [ADDR_W-1:0] ld_addr = '0;
   logic [OP_W-1:0] ld_data = '0;
   logic srch_valid = 1'b0;
   logic [OP_W-1:0] srch_w = '0, srch_a = '0;
   logic rsp_valid, rsp_hit, rsp_miss;
   logic [OP_W-1:0] rsp_result;
   logic [CNT_W-1:0] search_count, hit_count;

   int checks = 0;
   int errors = 0;
   int n_search = 0;
   int n_hit = 0;

   always #4 clk = ~clk;

   approx_product_cache #(.OP_W(OP_W), .KEY_W(KEY_W), .W_ROWS(WR), .A_ROWS(AR),
                          .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
      .ld_data(ld_data), .srch_valid(srch_valid), .srch_w(srch_w), .srch_a(srch_a),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_result(rsp_result), .search_count(search_count), .hit_count(hit_count));

   typedef struct packed {
      logic [7:0]  ab;
      logic [31:0] w;
      logic [31:0] a;
      logic        hit;
      logic [31:0] res;
   } vec_t;

   // product word i holds 32'h5000_0000 + i; address = w_row*4 + a_row
   localparam vec_t VECS [9] = '{
      '{8'd16, 32'h3F80_1234, 32'h4040_FFFF, 1'b1, 32'h5000_0000},
      '{8'd16, 32'h4000_0000, 32'h3F00_0000, 1'b1, 32'h5000_0005},
      '{8'd16, 32'hBF80_0000, 32'h0000_0001, 1'b1, 32'h5000_000A},
      '{8'd16, 32'h3F81_0000, 32'h4140_0000, 1'b1, 32'h5000_000F},
      '{8'd16, 32'h3F82_0000, 32'h4040_0000, 1'b0, 32'h0},
      '{8'd16, 32'h3F80_0000, 32'h4080_0000, 1'b0, 32'h0},
      '{8'd13, 32'h3F81_0000, 32'h4140_0000, 1'b1, 32'h5000_0003},
      '{8'd13, 32'h3F82_0000, 32'h4043_0000, 1'b1, 32'h5000_0000},
      '{8'd13, 32'h3F88_0000, 32'h4040_0000, 1'b0, 32'h0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [1:0] sel, input int addr, input logic [31:0] data);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_addr = ADDR_W'(addr); ld_data = data;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic search(input logic [31:0] w, input logic [31:0] a);
      @(negedge clk);
      srch_valid = 1'b1; srch_w = w; srch_a = a;
      @(posedge clk);
      @(negedge clk);
      srch_valid = 1'b0;
      n_search++;
      if (rsp_hit === 1'b1) n_hit++;
   endtask

   task automatic expect_rsp(input string req, input logic hit, input logic [31:0] res);
      check(req, {63'd0, rsp_valid}, 64'd1);
      check(req, {62'd0, rsp_hit, rsp_miss}, {62'd0, hit, !hit});
      check(req, {32'd0, rsp_result}, {32'd0, res});
   endtask

   task automatic fill();
      load(2'd0, 0, 32'h3F80_0000);
      load(2'd0, 1, 32'h4000_0000);
      load(2'd0, 2, 32'hBF80_0000);
      load(2'd0, 3, 32'h3F81_0000);
      load(2'd1, 0, 32'h4040_0000);
      load(2'd1, 1, 32'h3F00_0000);
      load(2'd1, 2, 32'h0000_0000);
      load(2'd1, 3, 32'h4140_0000);
      for (int i = 0; i < WR * AR; i++) load(2'd2, i, 32'h5000_0000 + 32'(i));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R5: reset state
      check("R5 rsp_valid", {63'd0, rsp_valid}, 64'd0);
      check("R5 search_count", {32'd0, search_count}, 64'd0);
      rst_n = 1'b1;
      search(32'h3F80_0000, 32'h4040_0000);
      expect_rsp("R5 empty arrays miss", 1'b0, 32'h0);
      fill();
      // R8: idle cycle
      @(negedge clk);
      check("R8 idle quiet", {61'd0, rsp_valid, rsp_hit, rsp_miss}, 64'd0);
      // R1 R2 R3 R4 R9 via table
      for (int v = 0; v < 9; v++) begin
         load(2'd3, 0, {24'd0, VECS[v].ab});
         search(VECS[v].w, VECS[v].a);
         expect_rsp($sformatf("R1/R2/R3/R4 vector %0d", v), VECS[v].hit, VECS[v].res);
      end
      // R6: clamp of oversize key length, then full compare picks row 3
      load(2'd3, 0, 32'd31);
      search(32'h3F81_0000, 32'h4140_0000);
      expect_rsp("R6 clamp to KEY_W", 1'b1, 32'h5000_000F);
      // R6: zero key length matches any valid row, lowest wins (R4)
      load(2'd3, 0, 32'd0);
      search(32'hFFFF_FFFF, 32'h1234_5678);
      expect_rsp("R6 zero key length", 1'b1, 32'h5000_0000);
      // R7: counters
      check("R7 search_count", {32'd0, search_count}, 64'(n_search));
      check("R7 hit_count", {32'd0, hit_count}, 64'(n_hit));
      // R5: reset mid-run invalidates rows and restores key length
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      n_search = 0; n_hit = 0;
      check("R5 counters cleared", {32'd0, hit_count}, 64'd0);
      search(32'h3F80_0000, 32'h4040_0000);
      expect_rsp("R5 rows invalid after reset", 1'b0, 32'h0);
      load(2'd0, 3, 32'h3F81_0000);
      load(2'd1, 0, 32'h4040_0000);
      search(32'h3F81_0000, 32'h4040_0000);
      expect_rsp("R5 key length restored, R9 reload", 1'b1, 32'h5000_000C);
      search(32'h3F80_0000, 32'h4040_0000);
      expect_rsp("R5 R3 full key misses neighbour", 1'b0, 32'h0);
      check("R7 search_count after reset", {32'd0, search_count}, 64'(n_search));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule